// File: doc/BRIEF.md
# Quad I/O Continuous-Read Flash Engine

This block fetches 32-bit words from a serial NOR flash wired with four data lines, in the style used for execute-in-place code fetch. A bus-side client presents a 24-bit byte address with a valid/ready handshake. The engine later returns the word with a one-cycle valid pulse. On the flash side it generates the serial clock and an active-low chip select. It also drives four IO lines through separate output, output-enable and input vectors, so that pad logic outside the block can form the bidirectional pins.

The first read after reset is preceded by a throw-away entry transaction. This transaction carries the quad fast-read instruction on a single line and then a mode byte that puts the flash into continuous-read mode. From then on, every read starts directly with the address and the same mode byte, followed by released dummy clocks and eight clocks of quad data. A separate exit request sends an address-only transaction whose mode byte breaks continuous mode. The next read then goes back through the entry transaction.

A request is accepted on the rising clock edge where `reqValid` and `reqReady` are both high. The serial clock runs at the system clock divided by `2*HALF_DIV`. Outputs change only while the serial clock is low, and input nibbles are captured on its rising edge.

Top module: `quad_xip_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `csN` is 1, `sclk` is 0, `ioOe` is 0, `reqReady` is 1 and `rspValid` is 0.
- R2: The first accepted read after reset (or after an exit) is preceded by its own chip-select window. That window sends instruction 0xEB on IO0 alone (`ioOe` = 4'b0001) for 8 SCLK cycles, MSB first, then address 0 and mode 0xA0. It runs through dummy and data cycles, and its data is discarded without a `rspValid` pulse.
- R3: The address phase lasts 8 SCLK cycles with `ioOe` = 4'hF. It sends the 32 bits {address[23:0], mode[7:0]} as nibbles, most significant nibble first, with IO3 carrying bit 3 of each nibble. Outputs do not change on a rising SCLK edge.
- R4: After the address phase, all four lines are released (`ioOe` = 0) for 4 dummy cycles and the 8 data cycles. A window therefore has 28 rising SCLK edges when it carries the instruction and 20 when it does not.
- R5: In the data phase, a nibble is sampled on each rising SCLK edge. Two consecutive nibbles form a byte, upper half first. The byte that arrives k-th (k = 0..3) is returned in `rspData[8k+7:8k]` alongside a `rspValid` pulse one cycle long.
- R6: While continuous mode is active, a read window begins directly with the address phase, with no instruction.
- R7: Every read window, and the entry window, sends mode byte 0xA0.
- R8: `exitReq` seen while idle in continuous mode starts a window with no instruction, address 0 and mode 0x00, with no `rspValid` pulse. The next read again begins with the entry window of R2.
- R9: `exitReq` while continuous mode is not active has no effect: no window opens and `reqReady` stays 1.
- R10: If `exitReq` and `reqValid` are both high in an idle cycle in continuous mode, the exit wins: `reqReady` is 0 and the request is not taken.
- R11: `reqReady` is 0 from the cycle after acceptance until the word is returned. While `csN` is high, `sclk` is 0 and `ioOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request valid |
| reqAddr | input | 24 | Byte address of the requested word |
| exitReq | input | 1 | Request to leave continuous-read mode |
| reqReady | output | 1 | Engine idle and able to take a request |
| rspValid | output | 1 | One-cycle pulse: `rspData` holds the returned word |
| rspData | output | 32 | Returned word, first received byte in the low byte |
| sclk | output | 1 | Serial flash clock |
| csN | output | 1 | Active-low flash chip select |
| ioOut | output | 4 | Values driven onto IO3..IO0 |
| ioOe | output | 4 | Per-line output enable for IO3..IO0 |
| ioIn | input | 4 | Values sampled from IO3..IO0 |

## Verification
The assertions assume that `reqValid`, `reqAddr` and `exitReq` are driven synchronously, and change only away from the rising system-clock edge. They also assume the flash returns nibbles on `ioIn` that are settled before each rising SCLK edge of the data phase. The bench drives all bus inputs on the falling system-clock edge. Its flash model updates `ioIn` only on falling SCLK edges, so it keeps within both assumptions. The model decodes each window independently: instruction present or absent, address, mode byte and edge count. It also tracks continuous mode from the mode nibble it received, so entry, exit and re-entry are judged from the pins.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_DONE
  } qxrState_e;

  // Purpose of the current chip-select window
  typedef enum logic [1:0] {
    TK_ENTRY,
    TK_READ,
    TK_EXIT
  } qxrKind_e;

  // Control-to-datapath strobes and phase levels
  typedef struct packed {
    logic latchReq;   // capture the bus address
    logic loadFrame;  // load instruction and address/mode shifters
    logic zeroAddr;   // frame carries address 0
    logic keepMode;   // frame carries the continue mode byte
    logic shiftCmd;   // advance instruction shifter
    logic shiftAddr;  // advance address/mode shifter
    logic capture;    // sample one data nibble
    logic publish;    // move assembled word to the response register
    logic driveCmd;   // single-line instruction phase
    logic driveQuad;  // four-line address phase
  } qxrStrobe_t;

endpackage

// File: rtl/qxr_ctrl.sv
module qxr_ctrl
  import qxr_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int CMD_CYC   = 8,
  parameter int ADDR_CYC  = 8,
  parameter int DUMMY_CYC = 4,
  parameter int DATA_CYC  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       exitReq,
  output logic       reqReady,
  output logic       rspValid,
  output logic       sclk,
  output logic       csN,
  output logic       contActive,
  output qxrStrobe_t strobe
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(CMD_CYC + ADDR_CYC + DUMMY_CYC + DATA_CYC + 1);

  qxrState_e       state;
  qxrKind_e        kind;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkQ;
  logic             contQ;
  logic             rspValidQ;

  logic             active;
  logic             tick;
  logic             riseEv;
  logic             fallEv;
  logic [CNT_W-1:0] phaseLen;
  logic             lastCyc;
  logic             takeExit;
  logic             takeReq;
  logic             entryDone;

  always_comb begin
    active    = (state == ST_CMD) || (state == ST_ADDR) ||
                (state == ST_DUMMY) || (state == ST_DATA);
    tick      = active && (divCnt == DIV_W'(HALF_DIV - 1));
    riseEv    = tick && !sclkQ;
    fallEv    = tick && sclkQ;
    unique case (state)
      ST_CMD:   phaseLen = CNT_W'(CMD_CYC);
      ST_ADDR:  phaseLen = CNT_W'(ADDR_CYC);
      ST_DUMMY: phaseLen = CNT_W'(DUMMY_CYC);
      ST_DATA:  phaseLen = CNT_W'(DATA_CYC);
      default:  phaseLen = CNT_W'(1);
    endcase
    lastCyc   = (bitCnt == phaseLen - CNT_W'(1));
    takeExit  = (state == ST_IDLE) && exitReq && contQ;
    takeReq   = (state == ST_IDLE) && reqValid && !takeExit;
    entryDone = (state == ST_DONE) && (kind == TK_ENTRY);
  end

  always_comb begin
    strobe.latchReq  = takeReq;
    strobe.loadFrame = takeReq || takeExit || entryDone;
    strobe.zeroAddr  = takeExit || (takeReq && !contQ);
    strobe.keepMode  = !takeExit;
    strobe.shiftCmd  = fallEv && (state == ST_CMD);
    strobe.shiftAddr = fallEv && (state == ST_ADDR);
    strobe.capture   = riseEv && (state == ST_DATA);
    strobe.publish   = (state == ST_DONE) && (kind == TK_READ);
    strobe.driveCmd  = (state == ST_CMD);
    strobe.driveQuad = (state == ST_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= TK_READ;
      divCnt    <= '0;
      bitCnt    <= '0;
      sclkQ     <= 1'b0;
      contQ     <= 1'b0;
      rspValidQ <= 1'b0;
    end else begin
      rspValidQ <= (state == ST_DONE) && (kind == TK_READ);
      unique case (state)
        ST_IDLE: begin
          divCnt <= '0;
          bitCnt <= '0;
          sclkQ  <= 1'b0;
          if (takeExit) begin
            state <= ST_ADDR;
            kind  <= TK_EXIT;
          end else if (takeReq) begin
            state <= contQ ? ST_ADDR : ST_CMD;
            kind  <= contQ ? TK_READ : TK_ENTRY;
          end
        end
        ST_DONE: begin
          divCnt <= '0;
          bitCnt <= '0;
          sclkQ  <= 1'b0;
          unique case (kind)
            TK_ENTRY: begin
              contQ <= 1'b1;
              kind  <= TK_READ;
              state <= ST_ADDR;
            end
            TK_EXIT: begin
              contQ <= 1'b0;
              state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
        default: begin
          divCnt <= tick ? '0 : divCnt + DIV_W'(1);
          if (riseEv) sclkQ <= 1'b1;
          if (fallEv) begin
            sclkQ <= 1'b0;
            if (lastCyc) begin
              bitCnt <= '0;
              unique case (state)
                ST_CMD:   state <= ST_ADDR;
                ST_ADDR:  state <= ST_DUMMY;
                ST_DUMMY: state <= ST_DATA;
                default:  state <= ST_DONE;
              endcase
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign reqReady   = (state == ST_IDLE) && !(exitReq && contQ);
  assign rspValid   = rspValidQ;
  assign sclk       = sclkQ;
  assign csN        = !active;
  assign contActive = contQ;

endmodule

// File: rtl/qxr_datapath.sv
module qxr_datapath
  import qxr_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter int         DATA_W    = 32,
  parameter logic [7:0] CMD_CODE  = 8'hEB,
  parameter logic [7:0] MODE_KEEP = 8'hA0,
  parameter logic [7:0] MODE_EXIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  qxrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [DATA_W-1:0] rspData
);

  localparam int FRAME_W = ADDR_W + 8;
  localparam int BYTES   = DATA_W / 8;

  logic [ADDR_W-1:0]  addrReg;
  logic [7:0]         cmdSh;
  logic [FRAME_W-1:0] frameSh;
  logic [DATA_W-1:0]  rawSh;
  logic [DATA_W-1:0]  swapped;
  logic [DATA_W-1:0]  rspQ;
  logic [ADDR_W-1:0]  srcAddr;
  logic [FRAME_W-1:0] frameVal;

  assign srcAddr  = strobe.latchReq ? reqAddr : addrReg;
  assign frameVal = {strobe.zeroAddr ? {ADDR_W{1'b0}} : srcAddr,
                     strobe.keepMode ? MODE_KEEP : MODE_EXIT};

  // First received byte ends up in the least significant position
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = rawSh[DATA_W-8-8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      cmdSh   <= '0;
      frameSh <= '0;
      rawSh   <= '0;
      rspQ    <= '0;
    end else begin
      if (strobe.latchReq) addrReg <= reqAddr;
      if (strobe.loadFrame) begin
        cmdSh   <= CMD_CODE;
        frameSh <= frameVal;
      end else begin
        if (strobe.shiftCmd)  cmdSh   <= {cmdSh[6:0], 1'b0};
        if (strobe.shiftAddr) frameSh <= {frameSh[FRAME_W-5:0], 4'b0000};
      end
      if (strobe.capture) rawSh <= {rawSh[DATA_W-5:0], ioIn};
      if (strobe.publish) rspQ  <= swapped;
    end
  end

  always_comb begin
    if (strobe.driveCmd) begin
      ioOut = {3'b000, cmdSh[7]};
      ioOe  = 4'b0001;
    end else if (strobe.driveQuad) begin
      ioOut = frameSh[FRAME_W-1 -: 4];
      ioOe  = 4'b1111;
    end else begin
      ioOut = 4'b0000;
      ioOe  = 4'b0000;
    end
  end

  assign rspData = rspQ;

endmodule

// File: rtl/quad_xip_reader.sv
module quad_xip_reader
  import qxr_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter int         DATA_W    = 32,
  parameter int         HALF_DIV  = 2,
  parameter int         DUMMY_CYC = 4,
  parameter logic [7:0] CMD_CODE  = 8'hEB,
  parameter logic [7:0] MODE_KEEP = 8'hA0,
  parameter logic [7:0] MODE_EXIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              exitReq,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sclk,
  output logic              csN,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn
);

  localparam int ADDR_CYC = (ADDR_W + 8) / 4;
  localparam int DATA_CYC = DATA_W / 4;

  qxrStrobe_t strobe;
  logic       contActive;

  qxr_ctrl #(
    .HALF_DIV (HALF_DIV),
    .CMD_CYC  (8),
    .ADDR_CYC (ADDR_CYC),
    .DUMMY_CYC(DUMMY_CYC),
    .DATA_CYC (DATA_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .exitReq   (exitReq),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .sclk      (sclk),
    .csN       (csN),
    .contActive(contActive),
    .strobe    (strobe)
  );

  qxr_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CMD_CODE (CMD_CODE),
    .MODE_KEEP(MODE_KEEP),
    .MODE_EXIT(MODE_EXIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqAddr(reqAddr),
    .ioIn   (ioIn),
    .ioOut  (ioOut),
    .ioOe   (ioOe),
    .rspData(rspData)
  );

endmodule

// File: rtl/qxr_checker.sv
module qxr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       exitReq,
  input logic       reqReady,
  input logic       rspValid,
  input logic       sclk,
  input logic       csN,
  input logic [3:0] ioOut,
  input logic [3:0] ioOe,
  input logic       contActive
);

  // R11: flash side quiet whenever chip select is high
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sclk && ioOe == 4'b0000));

  // R11: an accepted request blocks further requests next cycle
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5: response strobe is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R3: enable pattern is single-line, quad or released inside a window
  a_r3_oe_shape: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (ioOe == 4'b0000 || ioOe == 4'b0001 || ioOe == 4'b1111));

  // R3: driven values are settled across a rising serial clock edge
  a_r3_stable_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> ($stable(ioOut) && $stable(ioOe)));

  // R9: exit outside continuous mode opens no window
  a_r9_exit_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (csN && reqReady && exitReq && !reqValid && !contActive) |=> csN);

  // R10: exit wins over a simultaneous request in continuous mode
  a_r10_exit_first: assert property (@(posedge clk) disable iff (!rstN)
    (csN && exitReq && contActive) |-> !reqReady);

endmodule

bind quad_xip_reader qxr_checker u_qxr_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .exitReq   (exitReq),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .sclk      (sclk),
  .csN       (csN),
  .ioOut     (ioOut),
  .ioOe      (ioOe),
  .contActive(contActive)
);

// File: tb/tb_quad_xip_reader.sv
module tb_quad_xip_reader;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [23:0] reqAddr;
  logic        exitReq;
  logic        reqReady;
  logic        rspValid;
  logic [31:0] rspData;
  logic        sclk;
  logic        csN;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic [3:0]  flashDrive = 4'h0;

  always #2 clk = ~clk;

  quad_xip_reader dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .exitReq(exitReq), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .sclk(sclk), .csN(csN), .ioOut(ioOut),
    .ioOe(ioOe), .ioIn(flashDrive)
  );

  localparam int NVEC = 8;
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    24'h000000, 24'h000123, 24'hABCDEF, 24'hFFFFFC,
    24'h7FFFFF, 24'h100100, 24'h5A5A5A, 24'h00FF00
  };

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] expWord(input logic [23:0] a);
    return {mb(a + 24'd3), mb(a + 24'd2), mb(a + 24'd1), mb(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int          cyc = 0;
  bit          inTxn = 1'b0;
  bit          fCont = 1'b0;
  bit          cmdOn = 1'b0;
  logic [7:0]  cmdSh = '0;
  logic [31:0] amSh = '0;
  int          oeErr = 0;
  int          nTxn = 0;
  int          rspCount = 0;
  bit          recHadCmd [0:63];
  logic [7:0]  recCmd    [0:63];
  logic [23:0] recAddr   [0:63];
  logic [7:0]  recMode   [0:63];
  int          recEdges  [0:63];

  always @(negedge csN) begin
    cyc   = 0;
    inTxn = 1'b1;
    cmdOn = !fCont;
    cmdSh = '0;
    amSh  = '0;
  end

  always @(posedge csN) begin
    if (inTxn && nTxn < 64) begin
      recHadCmd[nTxn] = cmdOn;
      recCmd[nTxn]    = cmdSh;
      recAddr[nTxn]   = amSh[31:8];
      recMode[nTxn]   = amSh[7:0];
      recEdges[nTxn]  = cyc;
      nTxn++;
      fCont = (amSh[7:4] == 4'hA);
    end
    inTxn = 1'b0;
  end

  always @(posedge sclk) begin
    int k;
    if (!csN) begin
      k = cyc - (cmdOn ? 8 : 0);
      if (cmdOn && cyc < 8) begin
        cmdSh = {cmdSh[6:0], ioOut[0]};
        if (ioOe !== 4'b0001) oeErr++;
      end else if (k < 8) begin
        amSh = {amSh[27:0], ioOut};
        if (ioOe !== 4'b1111) oeErr++;
      end else if (ioOe !== 4'b0000) begin
        oeErr++;
      end
      cyc++;
    end
  end

  always @(negedge sclk) begin
    int k;
    int j;
    logic [7:0] b;
    if (!csN) begin
      k = cyc - (cmdOn ? 8 : 0);
      if (k >= 12 && k < 20) begin
        j = k - 12;
        b = mb(amSh[31:8] + 24'(j / 2));
        flashDrive = (j % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
  end

  always @(posedge clk) if (rstN === 1'b1 && rspValid === 1'b1) rspCount++;

  // ---------------- bus tasks ----------------
  task automatic doRead(input logic [23:0] a, output logic [31:0] d, output bit got);
    got = 1'b0;
    d   = '0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    #1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int w = 0; w < 3000 && !got; w++) begin
      if (rspValid) begin
        d   = rspData;
        got = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R11 watchdog: act=hung exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit          got;
    int          t0;
    int          r0;
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    exitReq  = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state while held
    chk("R1 csN", 32'(csN), 32'd1);
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 ioOe", 32'(ioOe), 32'd0);
    chk("R1 reqReady", 32'(reqReady), 32'd1);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 csN after release", 32'(csN), 32'd1);

    // R9: exit outside continuous mode does nothing
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 no window", 32'(nTxn), 32'd0);
    chk("R9 ready", 32'(reqReady), 32'd1);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      t0 = nTxn;
      doRead(VEC[i], d, got);
      repeat (3) @(negedge clk);
      chk("R11 response returned", 32'(got), 32'd1);
      chk("R5 data word", d, expWord(VEC[i]));
      if (i == 0) begin
        chk("R2 two windows", 32'(nTxn - t0), 32'd2);
        chk("R2 entry has instruction", 32'(recHadCmd[t0]), 32'd1);
        chk("R2 entry instruction", 32'(recCmd[t0]), 32'hEB);
        chk("R2 entry address", 32'(recAddr[t0]), 32'd0);
        chk("R7 entry mode", 32'(recMode[t0]), 32'hA0);
        chk("R4 entry edges", 32'(recEdges[t0]), 32'd28);
        t0 = t0 + 1;
      end else begin
        chk("R6 one window", 32'(nTxn - t0), 32'd1);
      end
      chk("R6 no instruction", 32'(recHadCmd[t0]), 32'd0);
      chk("R3 address", 32'(recAddr[t0]), 32'(VEC[i]));
      chk("R7 mode", 32'(recMode[t0]), 32'hA0);
      chk("R4 edges", 32'(recEdges[t0]), 32'd20);
    end
    chk("R2 pulses only for reads", 32'(rspCount), 32'(NVEC));

    // R10: exit and request together in continuous mode
    t0 = nTxn;
    r0 = rspCount;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 24'h123456;
    exitReq  = 1'b1;
    #1;
    chk("R10 ready low", 32'(reqReady), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    exitReq  = 1'b0;
    repeat (200) @(negedge clk);
    chk("R10 only exit window", 32'(nTxn - t0), 32'd1);
    chk("R8 exit no instruction", 32'(recHadCmd[t0]), 32'd0);
    chk("R8 exit address", 32'(recAddr[t0]), 32'd0);
    chk("R8 exit mode", 32'(recMode[t0]), 32'h00);
    chk("R8 exit edges", 32'(recEdges[t0]), 32'd20);
    chk("R8 no response", 32'(rspCount - r0), 32'd0);

    // R8: next read re-enters through the instruction window
    t0 = nTxn;
    doRead(24'h000040, d, got);
    repeat (3) @(negedge clk);
    chk("R8 reentry windows", 32'(nTxn - t0), 32'd2);
    chk("R8 reentry instruction", 32'(recCmd[t0]), 32'hEB);
    chk("R8 reentry has instruction", 32'(recHadCmd[t0]), 32'd1);
    chk("R5 data after reentry", d, expWord(24'h000040));

    // R3 R4: enable pattern in every phase
    chk("R3 R4 enable pattern", 32'(oeErr), 32'd0);
    chk("R11 idle after all", 32'(csN), 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule